// File: doc/BRIEF.md
# Pulse-Width Qualified Level Trigger

This block watches a stream of signed two's-complement samples and raises a single trigger pulse when the signal does what the selected mode asks for. A mode can ask for a plain crossing of an upper level, for a crossing whose duration past the level is qualified by a sample counter, or for the signal entering or leaving a band set by an upper and a lower level. The window modes can also be duration-qualified.

The trigger is a one-shot. Software, or a sequencer, pulses `arm`. The block then fires on the first qualifying sample and stays quiet until it is armed again. The signal state and the duration counter keep tracking every valid sample whether or not the block is armed, so a pulse that began before arming is measured from its true start.

Top module: `pw_level_trigger`

## Requirements
- R1: Edge modes compare against the upper level. A sample is "above" when it is strictly greater than the level. Mode code 0 fires when the previous valid sample was not above and the current one is. Code 1 fires on the reverse transition. Code 2 fires on either transition.
- R2: Long-pulse modes fire on the valid sample where the signal has stayed past the level for exactly `pulseWidth` consecutive samples. The sample that made the crossing counts as the first. A crossing back before that point cancels the trigger. Code 3 measures time above the upper level. Code 5 measures time at or below it, starting from a falling crossing.
- R3: Short-pulse modes fire on the sample that crosses back when the pulse lasted fewer than `pulseWidth` samples. A pulse of `pulseWidth` samples or more gives no trigger. Code 4 uses pulses above the upper level. Code 6 uses pulses at or below it.
- R4: The window is the band `levelLo <= sample <= levelHi`, compared as signed values. Code 7 fires on the first valid sample inside the band after one outside it. Code 8 fires on the first sample outside after one inside. A jump from above the band to below it, or from below to above, is neither entry nor exit.
- R5: Code 9 fires once the signal has stayed outside the window for `pulseWidth` consecutive samples. Code 10 fires when the signal re-enters the window after fewer than `pulseWidth` samples outside.
- R6: A `pulseWidth` value below 2 behaves as 2. The upper bound of 255 is the largest code the 8-bit port can carry.
- R7: A level programmed to the most negative code (0x80) behaves as the next code up, -127. This leaves 255 usable levels.
- R8: After an `arm` pulse the block fires on the first qualifying sample only. Later events are ignored until `arm` is pulsed again. If `arm` coincides with the sample that fires, the firing wins and the block is left disarmed.
- R9: `trigOut` is high for exactly one clock, in the cycle after the clock edge that captured the qualifying sample. Cycles with `sampleValid` low neither fire nor change the tracked signal state.
- R10: Mode codes 11 to 15 never fire.
- R11: After reset `trigOut` is low and the block is disarmed. It holds no previous sample, so the first valid sample after reset cannot form a crossing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | Marks `sampleIn` as a new sample |
| sampleIn | input | 8 | Signed sample |
| modeSel | input | 4 | Trigger mode code (see R1 to R5, R10) |
| levelHi | input | 8 | Signed upper level |
| levelLo | input | 8 | Signed lower level (window modes) |
| pulseWidth | input | 8 | Qualification width in samples |
| arm | input | 1 | One-cycle pulse that arms the one-shot |
| trigOut | output | 1 | One-cycle trigger pulse |

## Verification
The assertions assume that the mode, the levels and the width stay constant between two resets. The tracked crossing state belongs to the selected condition, so changing the mode while a pulse is being timed is outside the checked envelope. The stimulus therefore applies a reset before every configuration it sweeps. It pulses `arm` in a cycle with no valid sample, except in the directed case that tests a re-arm coinciding with a firing sample.

// File: rtl/pw_trig_pkg.sv
package pw_trig_pkg;

  localparam int MODE_W = 4;

  localparam logic [MODE_W-1:0] MODE_RISE       = 4'd0;
  localparam logic [MODE_W-1:0] MODE_FALL       = 4'd1;
  localparam logic [MODE_W-1:0] MODE_EITHER     = 4'd2;
  localparam logic [MODE_W-1:0] MODE_HI_LONG    = 4'd3;
  localparam logic [MODE_W-1:0] MODE_HI_SHORT   = 4'd4;
  localparam logic [MODE_W-1:0] MODE_LO_LONG    = 4'd5;
  localparam logic [MODE_W-1:0] MODE_LO_SHORT   = 4'd6;
  localparam logic [MODE_W-1:0] MODE_WIN_ENTER  = 4'd7;
  localparam logic [MODE_W-1:0] MODE_WIN_LEAVE  = 4'd8;
  localparam logic [MODE_W-1:0] MODE_OUT_LONG   = 4'd9;
  localparam logic [MODE_W-1:0] MODE_OUT_SHORT  = 4'd10;

  // which condition the datapath tracks (control -> datapath)
  typedef struct packed {
    logic above;
    logic notAbove;
    logic outside;
  } cond_sel_t;

  // per-sample events (datapath -> control)
  typedef struct packed {
    logic startEdge;
    logic endEdge;
    logic longHit;
    logic shortHit;
  } trig_evt_t;

endpackage

// File: rtl/pw_trig_datapath.sv
module pw_trig_datapath
  import pw_trig_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [DATA_W-1:0] levelHi,
  input  logic [DATA_W-1:0] levelLo,
  input  logic [DATA_W-1:0] pulseWidth,
  input  cond_sel_t         condSel,
  output trig_evt_t         evt
);

  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] PW_MIN   = DATA_W'(2);
  localparam logic [DATA_W-1:0] CNT_MAX  = '1;
  localparam logic [DATA_W-1:0] ONE      = DATA_W'(1);

  logic [DATA_W-1:0] hiEff, loEff, pwEff;
  logic              aboveHi, belowLo, cond, qual;
  logic              prevValid, prevCond, running;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W:0]   cntInc;

  // level and width conditioning
  always_comb begin
    hiEff = (levelHi == MOST_NEG) ? MOST_NEG + ONE : levelHi;
    loEff = (levelLo == MOST_NEG) ? MOST_NEG + ONE : levelLo;
    pwEff = (pulseWidth < PW_MIN) ? PW_MIN : pulseWidth;
  end

  always_comb begin
    aboveHi = $signed(sampleIn) > $signed(hiEff);
    belowLo = $signed(sampleIn) < $signed(loEff);
    cond    = (condSel.above    &  aboveHi) |
              (condSel.notAbove & ~aboveHi) |
              (condSel.outside  & (aboveHi | belowLo));
    qual    = sampleValid & prevValid;
    cntInc  = {1'b0, cnt} + (DATA_W+1)'(1);
  end

  always_comb begin
    evt.startEdge = qual &  cond & ~prevCond;
    evt.endEdge   = qual & ~cond &  prevCond;
    evt.longHit   = qual & running &  cond & (cntInc == {1'b0, pwEff});
    evt.shortHit  = qual & running & ~cond & (cnt < pwEff);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevValid <= 1'b0;
      prevCond  <= 1'b0;
      running   <= 1'b0;
      cnt       <= '0;
    end else if (sampleValid) begin
      prevValid <= 1'b1;
      prevCond  <= cond;
      if (evt.startEdge) begin
        running <= 1'b1;
        cnt     <= ONE;
      end else if (evt.endEdge) begin
        running <= 1'b0;
      end else if (running && cond && cnt != CNT_MAX) begin
        cnt <= cnt + ONE;
      end
    end
  end

endmodule

// File: rtl/pw_trig_control.sv
module pw_trig_control
  import pw_trig_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              arm,
  input  trig_evt_t         evt,
  output cond_sel_t         condSel,
  output logic              trigOut
);

  logic armed, hit, fire;

  always_comb begin
    condSel = '0;
    hit     = 1'b0;
    case (modeSel)
      MODE_RISE:      begin condSel.above    = 1'b1; hit = evt.startEdge; end
      MODE_FALL:      begin condSel.above    = 1'b1; hit = evt.endEdge; end
      MODE_EITHER:    begin condSel.above    = 1'b1; hit = evt.startEdge | evt.endEdge; end
      MODE_HI_LONG:   begin condSel.above    = 1'b1; hit = evt.longHit; end
      MODE_HI_SHORT:  begin condSel.above    = 1'b1; hit = evt.shortHit; end
      MODE_LO_LONG:   begin condSel.notAbove = 1'b1; hit = evt.longHit; end
      MODE_LO_SHORT:  begin condSel.notAbove = 1'b1; hit = evt.shortHit; end
      MODE_WIN_ENTER: begin condSel.outside  = 1'b1; hit = evt.endEdge; end
      MODE_WIN_LEAVE: begin condSel.outside  = 1'b1; hit = evt.startEdge; end
      MODE_OUT_LONG:  begin condSel.outside  = 1'b1; hit = evt.longHit; end
      MODE_OUT_SHORT: begin condSel.outside  = 1'b1; hit = evt.shortHit; end
      default:        begin condSel = '0; hit = 1'b0; end
    endcase
    fire = armed & hit;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      trigOut <= 1'b0;
    end else begin
      trigOut <= fire;
      if (fire)     armed <= 1'b0;
      else if (arm) armed <= 1'b1;
    end
  end

endmodule

// File: rtl/pw_level_trigger.sv
module pw_level_trigger
  import pw_trig_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] sampleIn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic [DATA_W-1:0] levelHi,
  input  logic [DATA_W-1:0] levelLo,
  input  logic [DATA_W-1:0] pulseWidth,
  input  logic              arm,
  output logic              trigOut
);

  cond_sel_t condSel;
  trig_evt_t evt;

  pw_trig_datapath #(.DATA_W(DATA_W)) datapath_i (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleIn   (sampleIn),
    .levelHi    (levelHi),
    .levelLo    (levelLo),
    .pulseWidth (pulseWidth),
    .condSel    (condSel),
    .evt        (evt)
  );

  pw_trig_control control_i (
    .clk    (clk),
    .rstN   (rstN),
    .modeSel(modeSel),
    .arm    (arm),
    .evt    (evt),
    .condSel(condSel),
    .trigOut(trigOut)
  );

endmodule

// File: rtl/pw_level_trigger_chk.sv
module pw_level_trigger_chk (
  input logic       clk,
  input logic       rstN,
  input logic       sampleValid,
  input logic [3:0] modeSel,
  input logic       arm,
  input logic       trigOut
);

  // set by an arm pulse, cleared once a trigger has been seen
  logic armSinceFire;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        armSinceFire <= 1'b0;
    else if (arm)     armSinceFire <= 1'b1;
    else if (trigOut) armSinceFire <= 1'b0;
  end

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |=> !trigOut);

  p_fire_needs_arm_r8: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> armSinceFire);

  p_after_valid_r9: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> $past(sampleValid));

  p_off_modes_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    trigOut |-> ($past(modeSel) <= 4'd10));

endmodule

bind pw_level_trigger pw_level_trigger_chk chk_i (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .modeSel    (modeSel),
  .arm        (arm),
  .trigOut    (trigOut)
);

// File: tb/pw_level_trigger_tb_top.sv
module pw_level_trigger_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 190000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [7:0] sampleIn = '0;
  logic [3:0] modeSel = '0;
  logic [7:0] levelHi = '0;
  logic [7:0] levelLo = '0;
  logic [7:0] pulseWidth = '0;
  logic       arm = 1'b0;
  logic       trigOut;

  int testsRun = 0;
  int testsFailed = 0;
  int cycles = 0;
  bit done = 1'b0;

  // reference model state, written from the requirements
  bit mPrevValid, mPrevCond, mRun, mArmed;
  int mCnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  pw_level_trigger dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .sampleIn(sampleIn),
    .modeSel(modeSel), .levelHi(levelHi), .levelLo(levelLo),
    .pulseWidth(pulseWidth), .arm(arm), .trigOut(trigOut)
  );

  function automatic int lvl(logic [7:0] code);
    int v = int'($signed(code));
    return (v == -128) ? -127 : v;   // R7
  endfunction

  function automatic bit condOf(int s);
    int md = int'(modeSel);
    bit above = s > lvl(levelHi);
    bit outside = above || (s < lvl(levelLo));
    if (md <= 4) return above;
    if (md <= 6) return !above;
    return outside;
  endfunction

  function automatic string tagOf(int md, int pw);
    string t;
    if (md <= 2) t = "R1";
    else if (md == 3 || md == 5) t = "R2";
    else if (md == 4 || md == 6) t = "R3";
    else if (md <= 8) t = "R4";
    else if (md <= 10) t = "R5";
    else t = "R10";
    if (pw < 2) t = {t, "/R6"};
    return t;
  endfunction

  task automatic check(string tag, logic act, logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: trigOut=%0b expected %0b (mode %0d, t=%0t)",
               tag, act, exp, modeSel, $time);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; sampleValid = 1'b0; arm = 1'b0;
    repeat (2) @(negedge clk);
    check("R11", trigOut, 1'b0);
    rstN = 1'b1;
    mPrevValid = 0; mPrevCond = 0; mRun = 0; mArmed = 0; mCnt = 0;
    @(negedge clk);
    check("R11", trigOut, 1'b0);
  endtask

  // one cycle: drive at negedge, observe a quarter period after posedge
  task automatic drive(bit v, int s, bit a, output logic obs, output logic expM);
    bit c, ev, st, en, lg, sh, fire;
    int md = int'(modeSel);
    int pwE = (int'(pulseWidth) < 2) ? 2 : int'(pulseWidth);
    sampleValid = v; sampleIn = 8'(s); arm = a;
    ev = 0;
    if (v) begin
      c = condOf(s);
      if (mPrevValid) begin
        st = c && !mPrevCond;
        en = !c && mPrevCond;
        lg = mRun && c && (mCnt + 1 == pwE);
        sh = mRun && !c && (mCnt < pwE);
        case (md)
          0: ev = st;      1: ev = en;      2: ev = st || en;
          3, 5, 9: ev = lg;
          4, 6, 10: ev = sh;
          7: ev = en;      8: ev = st;
          default: ev = 0;
        endcase
        if (st) begin mRun = 1; mCnt = 1; end
        else if (en) mRun = 0;
        else if (mRun && c && mCnt < 255) mCnt++;
      end
      mPrevValid = 1;
      mPrevCond = c;
    end
    fire = mArmed && ev;
    if (fire) mArmed = 0; else if (a) mArmed = 1;
    @(posedge clk);
    #(CLK_PERIOD/4);
    obs = trigOut;
    expM = fire;
    @(negedge clk);
    sampleValid = 1'b0; arm = 1'b0;
  endtask

  task automatic stepExp(bit v, int s, bit a, logic exp, string tag);
    logic obs, expM;
    drive(v, s, a, obs, expM);
    check(tag, obs, exp);
  endtask

  task automatic stepModel(bit v, int s, bit a, string tag);
    logic obs, expM;
    drive(v, s, a, obs, expM);
    check(tag, obs, expM);
  endtask

  initial begin : watchdog
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > WATCHDOG) begin
        testsRun++; testsFailed++;
        $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
        $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
        $finish;
      end
    end
  end

  initial begin : stimulus
    int bases[6];
    int pulses[6];
    int pws[5];
    bases  = '{0, 0, 50, 50, 0, -50};
    pulses = '{50, -50, 0, -50, 10, 50};
    pws    = '{0, 2, 3, 5, 255};
    @(negedge clk);

    // R11: reset state, first sample cannot cross
    modeSel = 4'd0; levelHi = 8'd10; levelLo = 8'(-10); pulseWidth = 8'd3;
    doReset();
    stepExp(0, 0, 1, 1'b0, "R11");
    stepExp(1, 50, 0, 1'b0, "R11");
    stepExp(1, 0, 0, 1'b0, "R1");
    stepExp(1, 50, 0, 1'b1, "R1");

    // R9: invalid cycles are ignored
    doReset();
    stepExp(1, 0, 0, 1'b0, "R9");
    stepExp(0, 0, 1, 1'b0, "R9");
    stepExp(0, 50, 0, 1'b0, "R9");
    stepExp(1, 0, 0, 1'b0, "R9");
    stepExp(1, 50, 0, 1'b1, "R9");
    stepExp(1, 50, 0, 1'b0, "R9");

    // R8: one-shot, and a coinciding re-arm is dropped
    doReset();
    stepExp(1, 0, 0, 1'b0, "R8");
    stepExp(0, 0, 1, 1'b0, "R8");
    stepExp(1, 50, 1, 1'b1, "R8");
    stepExp(1, 0, 0, 1'b0, "R8");
    stepExp(1, 50, 0, 1'b0, "R8");
    stepExp(0, 0, 1, 1'b0, "R8");
    stepExp(1, 0, 0, 1'b0, "R8");
    stepExp(1, 50, 0, 1'b1, "R8");
    stepExp(1, 0, 0, 1'b0, "R8");
    stepExp(1, 50, 0, 1'b0, "R8");

    // R7: level code 0x80 acts as -127
    levelHi = 8'h80;
    doReset();
    stepExp(1, -128, 0, 1'b0, "R7");
    stepExp(0, 0, 1, 1'b0, "R7");
    stepExp(1, -127, 0, 1'b0, "R7");
    stepExp(1, -126, 0, 1'b1, "R7");

    // R6: width 0 behaves as 2 in long-pulse mode
    modeSel = 4'd3; levelHi = 8'd10; pulseWidth = 8'd0;
    doReset();
    stepExp(1, 0, 0, 1'b0, "R6");
    stepExp(0, 0, 1, 1'b0, "R6");
    stepExp(1, 50, 0, 1'b0, "R6");
    stepExp(1, 50, 0, 1'b1, "R6");

    // R4: jump across the band is neither entry nor exit
    modeSel = 4'd7; pulseWidth = 8'd3;
    doReset();
    stepExp(1, 50, 0, 1'b0, "R4");
    stepExp(0, 0, 1, 1'b0, "R4");
    stepExp(1, -50, 0, 1'b0, "R4");
    stepExp(1, -10, 0, 1'b1, "R4");

    // sweep: all mode codes, widths, pulse lengths and level patterns
    levelHi = 8'd10; levelLo = 8'(-10);
    for (int md = 0; md < 16; md++) begin
      for (int wi = 0; wi < 5; wi++) begin
        for (int len = 1; len <= 6; len++) begin
          for (int vi = 0; vi < 6; vi++) begin
            string tag;
            modeSel = 4'(md);
            pulseWidth = 8'(pws[wi]);
            tag = tagOf(md, pws[wi]);
            doReset();
            stepModel(1, bases[vi], 0, tag);
            stepModel(0, 0, 1, tag);
            repeat (2) stepModel(1, bases[vi], 0, tag);
            repeat (len) stepModel(1, pulses[vi], 0, tag);
            repeat (4) stepModel(1, bases[vi], 0, tag);
          end
        end
      end
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule